// File: doc/BRIEF.md
# Interleaved Complex Sample Mixer

This block takes complex samples that share one input bus, one component at a time, and multiplies each sample by a cosine/sine local-oscillator pair. The in-phase word comes first, marked by a one-cycle strobe. The quadrature word follows on the same bus, one clock later or a longer, fixed number of clocks later, as a per-sample lag select input chooses. Both lanes share one pair of multipliers, and the work is split over two cycles. In the strobe cycle the multipliers form the in-phase products, which are held in registers. In the quadrature cycle the same multipliers form the quadrature products, and these are added to or subtracted from the held values to give the two mixed outputs.

A strobe always marks an in-phase word. If a strobe arrives while a quadrature word is still awaited, the pending sample is dropped and a new one starts. This includes a strobe that lands on the cycle where the quadrature word was due. Each finished sample gives a one-cycle valid pulse. The mixed results stay on the outputs until the next pulse.

Top module: `cmix_iq_mixer`

## Requirements
- R1: While reset is asserted and after it is released, `mix_valid` is 0 and `mix_re` and `mix_im` are 0 until the first sample completes.
- R2: When the lag select is 0 in the strobe cycle, the bus word in the next clock is taken as Q. Then `mix_re` = I·cos − Q·sin and `mix_im` = I·sin + Q·cos, in full-precision signed two's complement (33 bits at the default widths). They appear with `mix_valid` = 1 in the cycle after the Q cycle.
- R3: When the lag select is 1 in the strobe cycle, Q is the bus word two clocks after the strobe. The bus word in the cycle between is ignored. Timing and arithmetic are otherwise as in R2.
- R4: The lag select is sampled only in the strobe cycle. Its value in any other cycle has no effect.
- R5: The cosine and sine inputs are used only in the strobe cycle and the Q cycle of a sample, and are held equal across that span. Their values in other cycles have no effect.
- R6: A strobe that arrives before the pending Q has been captured, including a strobe on the Q cycle itself, discards the pending sample. That sample never produces a valid pulse, and the new strobe starts a fresh sample.
- R7: `mix_valid` is a single-cycle pulse, exactly one for each completed sample. A new strobe may follow the Q cycle directly.
- R8: `mix_re` and `mix_im` change only in a cycle where `mix_valid` is 1, and hold their values otherwise.
- R9: Full-scale operands, such as I = cos = Q = −32768 with sin = 32767, give exact results with no wrap-around.
- R10: Bus activity with no strobe while no sample is pending produces no valid pulse and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_strobe | input | 1 | Marks the cycle in which `smp_data` carries I |
| smp_data | input | DW | Shared I/Q data bus, signed |
| q_lag_long | input | 1 | 0: Q one clock after I; 1: Q LONG_LAG clocks after I (2 by default) |
| lo_cos | input | CW | Oscillator cosine value, signed |
| lo_sin | input | CW | Oscillator sine value, signed |
| mix_valid | output | 1 | One-cycle pulse when a mixed result is presented |
| mix_re | output | OW | I·cos − Q·sin, signed, MSB-aligned truncation when OW is below full width |
| mix_im | output | OW | I·sin + Q·cos, signed, MSB-aligned truncation when OW is below full width |

## Verification
The assertions assume that reset is low from time zero. They also assume the oscillator inputs stay steady in every cycle in which a sample is pending and no new strobe is present. The mixer does not re-register those inputs, so it depends on this. The bench changes cosine and sine only in strobe cycles and in idle cycles. It keeps them fixed through the gap and Q cycles. It toggles the lag select and the bus freely in every non-strobe cycle, so the ignored-input requirements are exercised inside the same bounds.

// File: rtl/cmix_pkg.sv
package cmix_pkg;

   typedef enum logic {
      LANE_ADD = 1'b0,
      LANE_SUB = 1'b1
   } lane_op_e;

   function automatic int unsigned cmix_full_w(input int unsigned dw, input int unsigned cw);
      return dw + cw + 1;
   endfunction

endpackage

// File: rtl/cmix_seq.sv
module cmix_seq #(
   parameter int unsigned LONG_LAG = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic lag_long,
   output logic q_take,
   output logic pending
);

   localparam int unsigned RW = $clog2(LONG_LAG);

   logic [RW-1:0] rem_q;
   logic          pend_q;
   logic          lag_r;

   initial begin
      if (LONG_LAG < 2) $fatal(1, "cmix_seq: LONG_LAG must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         rem_q  <= '0;
         lag_r  <= 1'b0;
      end else if (strobe) begin
         pend_q <= 1'b1;
         lag_r  <= lag_long;
         rem_q  <= lag_long ? RW'(LONG_LAG - 1) : '0;
      end else if (pend_q) begin
         if (rem_q == '0) pend_q <= 1'b0;
         else             rem_q  <= rem_q - RW'(1);
      end
   end

   assign q_take  = pend_q && !strobe && (rem_q == '0);
   assign pending = pend_q;

   // R2
   short_lag_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_take && !lag_r) |-> $past(strobe));

   // R3
   long_lag_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_take && lag_r) |-> !$past(strobe));

endmodule

// File: rtl/cmix_lane.sv
module cmix_lane
   import cmix_pkg::*;
#(
   parameter int unsigned DW = 16,
   parameter int unsigned CW = 16,
   parameter lane_op_e    OP = LANE_ADD
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_first,
   input  logic                    ld_second,
   input  logic signed [DW-1:0]    x,
   input  logic signed [CW-1:0]    c_first,
   input  logic signed [CW-1:0]    c_second,
   output logic signed [DW+CW:0]   res
);

   localparam int unsigned PW = DW + CW;
   localparam int unsigned FW = PW + 1;

   logic signed [CW-1:0] c_sel;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] first_q;
   logic signed [FW-1:0] sum_nx;
   logic signed [FW-1:0] res_q;

   // one multiplier per lane, shared between the I and Q cycles
   assign c_sel = ld_second ? c_second : c_first;
   assign prod  = PW'(x) * PW'(c_sel);

   generate
      if (OP == LANE_SUB) begin : g_sub
         assign sum_nx = FW'(first_q) - FW'(prod);
      end else begin : g_add
         assign sum_nx = FW'(first_q) + FW'(prod);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         res_q   <= '0;
      end else begin
         if (ld_first)  first_q <= prod;
         if (ld_second) res_q   <= sum_nx;
      end
   end

   assign res = res_q;

   // R6
   load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_first && ld_second));

   // R8
   lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_second |=> $stable(res));

endmodule

// File: rtl/cmix_trunc.sv
module cmix_trunc #(
   parameter int unsigned IW = 33,
   parameter int unsigned OW = 33
) (
   input  logic signed [IW-1:0] d,
   output logic signed [OW-1:0] q
);

   initial begin
      if (OW < 1 || OW > IW) $fatal(1, "cmix_trunc: OW must be in 1..IW");
   end

   generate
      if (OW == IW) begin : g_full
         assign q = d;
      end else begin : g_cut
         assign q = d[IW-1 -: OW];
      end
   endgenerate

endmodule

// File: rtl/cmix_iq_mixer.sv
module cmix_iq_mixer
   import cmix_pkg::*;
#(
   parameter int unsigned DW       = 16,
   parameter int unsigned CW       = 16,
   parameter int unsigned OW       = 33,
   parameter int unsigned LONG_LAG = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_strobe,
   input  logic signed [DW-1:0] smp_data,
   input  logic                 q_lag_long,
   input  logic signed [CW-1:0] lo_cos,
   input  logic signed [CW-1:0] lo_sin,
   output logic                 mix_valid,
   output logic signed [OW-1:0] mix_re,
   output logic signed [OW-1:0] mix_im
);

   localparam int unsigned FW    = cmix_full_w(DW, CW);
   localparam int unsigned LANES = 2;

   initial begin
      if (DW < 2) $fatal(1, "cmix_iq_mixer: DW must be at least 2");
      if (CW < 2) $fatal(1, "cmix_iq_mixer: CW must be at least 2");
      if (OW < 1 || OW > FW) $fatal(1, "cmix_iq_mixer: OW must be in 1..DW+CW+1");
   end

   logic q_take;
   logic pending;
   logic valid_q;

   logic signed [CW-1:0] coef_a   [LANES];
   logic signed [CW-1:0] coef_b   [LANES];
   logic signed [FW-1:0] lane_res [LANES];
   logic signed [OW-1:0] lane_out [LANES];

   cmix_seq #(
      .LONG_LAG (LONG_LAG)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (smp_strobe),
      .lag_long (q_lag_long),
      .q_take   (q_take),
      .pending  (pending)
   );

   // lane 0: I*cos then minus Q*sin; lane 1: I*sin then plus Q*cos
   assign coef_a[0] = lo_cos;
   assign coef_b[0] = lo_sin;
   assign coef_a[1] = lo_sin;
   assign coef_b[1] = lo_cos;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         localparam lane_op_e LOP = (g == 0) ? LANE_SUB : LANE_ADD;

         cmix_lane #(
            .DW (DW),
            .CW (CW),
            .OP (LOP)
         ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_first  (smp_strobe),
            .ld_second (q_take),
            .x         (smp_data),
            .c_first   (coef_a[g]),
            .c_second  (coef_b[g]),
            .res       (lane_res[g])
         );

         cmix_trunc #(
            .IW (FW),
            .OW (OW)
         ) u_trunc (
            .d (lane_res[g]),
            .q (lane_out[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= q_take;
   end

   assign mix_valid = valid_q;
   assign mix_re    = lane_out[0];
   assign mix_im    = lane_out[1];

   // R5
   coef_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !smp_strobe) |-> ($stable(lo_cos) && $stable(lo_sin)));

   // R6
   restart_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_strobe |=> !mix_valid);

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mix_valid |=> !mix_valid);

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mix_valid |-> ($stable(mix_re) && $stable(mix_im)));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && !smp_strobe) |=> !mix_valid);

endmodule

// File: tb/tb_cmix_iq_mixer.sv
`timescale 1ns/1ps
module tb_cmix_iq_mixer;

   localparam int DW = 16;
   localparam int CW = 16;
   localparam int FW = 33;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 smp_strobe = 1'b0;
   logic signed [DW-1:0] smp_data = '0;
   logic                 q_lag_long = 1'b0;
   logic signed [CW-1:0] lo_cos = '0;
   logic signed [CW-1:0] lo_sin = '0;
   logic                 mix_valid;
   logic signed [FW-1:0] mix_re;
   logic signed [FW-1:0] mix_im;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   logic signed [FW-1:0] exp_re_q [$];
   logic signed [FW-1:0] exp_im_q [$];
   int                   exp_cyc_q [$];
   string                exp_tag_q [$];

   logic signed [FW-1:0] prev_re;
   logic signed [FW-1:0] prev_im;
   bit                   prev_ok = 1'b0;

   cmix_iq_mixer #(
      .DW (DW), .CW (CW), .OW (FW), .LONG_LAG (2)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_strobe (smp_strobe),
      .smp_data   (smp_data),
      .q_lag_long (q_lag_long),
      .lo_cos     (lo_cos),
      .lo_sin     (lo_sin),
      .mix_valid  (mix_valid),
      .mix_re     (mix_re),
      .mix_im     (mix_im)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every valid pulse
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (mix_valid) begin
            if (exp_re_q.size() == 0) begin
               chk(1'b0, "R6/R10", "valid with no sample due", 1, 0);
            end else begin
               logic signed [FW-1:0] er, ei;
               int ec;
               string et;
               er = exp_re_q.pop_front();
               ei = exp_im_q.pop_front();
               ec = exp_cyc_q.pop_front();
               et = exp_tag_q.pop_front();
               chk(mix_re == er, et, "mix_re", longint'(mix_re), longint'(er));
               chk(mix_im == ei, et, "mix_im", longint'(mix_im), longint'(ei));
               chk(cyc == ec, et, "valid cycle", cyc, ec);
            end
         end else if (prev_ok) begin
            // R8 outputs hold between pulses
            chk(mix_re == prev_re && mix_im == prev_im, "R8", "hold re",
                longint'(mix_re), longint'(prev_re));
         end
         prev_re = mix_re;
         prev_im = mix_im;
         prev_ok = 1'b1;
      end
   end

   task automatic drive_idle(input int n);
      repeat (n) begin
         @(negedge clk);
         smp_strobe = 1'b0;
         smp_data   = DW'($urandom);
         q_lag_long = 1'($urandom);
         lo_cos     = CW'($urandom);
         lo_sin     = CW'($urandom);
      end
   endtask

   task automatic send(input int i_v, input int q_v, input bit lag,
                       input int c_v, input int s_v, input string tag);
      logic signed [DW-1:0] si, sq;
      logic signed [CW-1:0] sc, ss;
      longint er, ei;
      si = DW'(i_v); sq = DW'(q_v); sc = CW'(c_v); ss = CW'(s_v);
      @(negedge clk);
      smp_strobe = 1'b1;
      smp_data   = si;
      q_lag_long = lag;
      lo_cos     = sc;
      lo_sin     = ss;
      if (lag) begin
         @(negedge clk);
         smp_strobe = 1'b0;
         smp_data   = DW'($urandom);
         q_lag_long = 1'($urandom);
      end
      @(negedge clk);
      smp_strobe = 1'b0;
      smp_data   = sq;
      q_lag_long = 1'($urandom);
      er = longint'(si) * longint'(sc) - longint'(sq) * longint'(ss);
      ei = longint'(si) * longint'(ss) + longint'(sq) * longint'(sc);
      exp_re_q.push_back(FW'(er));
      exp_im_q.push_back(FW'(ei));
      exp_cyc_q.push_back(cyc + 1);
      exp_tag_q.push_back(tag);
   endtask

   // strobe a sample that will be cut short by the next strobe
   task automatic abandon(input int i_v, input bit lag, input bit extra);
      @(negedge clk);
      smp_strobe = 1'b1;
      smp_data   = DW'(i_v);
      q_lag_long = lag;
      lo_cos     = CW'($urandom);
      lo_sin     = CW'($urandom);
      if (extra) begin
         @(negedge clk);
         smp_strobe = 1'b0;
         smp_data   = DW'($urandom);
         q_lag_long = 1'($urandom);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(mix_valid == 1'b0, "R1", "valid in reset", longint'(mix_valid), 0);
      chk(mix_re == '0, "R1", "re in reset", longint'(mix_re), 0);
      chk(mix_im == '0, "R1", "im in reset", longint'(mix_im), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mix_valid == 1'b0 && mix_re == '0, "R1", "after release",
          longint'(mix_re), 0);

      // R10 idle bus activity
      drive_idle(6);

      // R2 short lag
      send(1000, -2000, 1'b0, 12000, -5000, "R2");
      drive_idle(2);
      for (int k = 0; k < 6; k++) begin
         send(int'($urandom), int'($urandom), 1'b0, int'($urandom), int'($urandom), "R2");
         drive_idle(1 + k % 3);
      end

      // R3 long lag, R4 lag flips during gap
      send(-300, 7000, 1'b1, -20000, 31000, "R3");
      drive_idle(3);
      for (int k = 0; k < 6; k++) begin
         send(int'($urandom), int'($urandom), 1'b1, int'($urandom), int'($urandom), "R4");
         drive_idle(k % 2 + 1);
      end

      // R7 back-to-back samples, mixed lags
      for (int k = 0; k < 10; k++) begin
         send(int'($urandom), int'($urandom), 1'(k % 3 == 0), int'($urandom), int'($urandom), "R7");
      end
      drive_idle(4);

      // R9 full-scale operands
      send(-32768, -32768, 1'b0, -32768, 32767, "R9");
      send(-32768, 32767, 1'b1, -32768, -32768, "R9");
      send(32767, -32768, 1'b0, 32767, -32768, "R9");
      drive_idle(3);

      // R6 restarts: strobe on Q slot (short and long) and in the gap
      abandon(1111, 1'b0, 1'b0);
      send(222, 333, 1'b0, 4000, 5000, "R6");
      drive_idle(2);
      abandon(-999, 1'b1, 1'b1);
      send(-444, 555, 1'b1, -6000, 7000, "R6");
      drive_idle(2);
      abandon(777, 1'b1, 1'b0);
      send(888, -999, 1'b0, 1234, -4321, "R6");

      // R5 coefficients change freely while idle
      for (int k = 0; k < 5; k++) begin
         drive_idle(2);
         send(int'($urandom), int'($urandom), 1'(k % 2), int'($urandom), int'($urandom), "R5");
      end
      drive_idle(6);

      chk(exp_re_q.size() == 0, "R6", "outstanding results", exp_re_q.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule